// File: doc/BRIEF.md
# Destination Address Exact-Match Filter

This block sits on the receive side of an Ethernet MAC and decides, for every incoming frame, whether the destination address is one the station wants. It keeps a table of ten 6-byte address slots. Slot 0 holds the station's own unicast address and slots 1 to 9 hold group addresses. Three control bits add promiscuous acceptance and all-group acceptance on top of the exact-match check.

The host loads the table one byte at a time through a window of eight consecutive register pages of eight bytes each. A slot can therefore straddle two pages. Every slot comes out of reset as all-ones, so any slot the host leaves unused matches the broadcast address. A build parameter selects whether each slot holds its six bytes in wire order or in reversed order.

The MAC presents the destination address one byte per valid cycle after a start-of-frame pulse. The block compares each byte against a per-frame copy of the table, keeping one running match flag per slot. One cycle after the sixth byte it reports accept or reject, together with the lowest matching slot.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0, `dec_slot` is 4'hF, every table byte is 8'hFF and all three control bits are 0.
- R2: A host write with `tbl_we` high stores `tbl_wdata` at table byte (tbl_page - PAGE_BASE)*8 + tbl_offs, but only when tbl_page lies in PAGE_BASE..PAGE_BASE+7 (default PAGE_BASE = 8'h50). Slot s occupies table bytes 6s..6s+5. Writes to pages outside the window and writes to bytes 60..63 change nothing.
- R3: With REVERSE_BYTES = 0, stored slot byte k is compared with the k-th destination byte on the wire. With REVERSE_BYTES = 1, it is compared with destination byte 5-k.
- R4: `dec_valid` is high for exactly one cycle, the cycle after the sixth `rx_valid` byte that follows `frm_start`. A byte presented in the same cycle as `frm_start` is not counted, and bytes after the sixth are ignored until the next `frm_start`.
- R5: With control bit 0 (exact enable) set, a frame whose six destination bytes all equal a slot is accepted, and `dec_slot` gives the lowest-numbered such slot.
- R6: A slot left at its reset value of all-ones matches the broadcast address FF:FF:FF:FF:FF:FF.
- R7: Control bit 1 (promiscuous) accepts every frame. `dec_slot` is 4'hF unless an exact match also occurred.
- R8: Control bit 2 (all-group) accepts every frame whose first destination byte has bit 0 set. `dec_slot` is 4'hF unless an exact match also occurred.
- R9: A frame accepted by no rule gives `dec_accept` = 0 and `dec_slot` = 4'hF. When control bit 0 is clear, no slot counts as a match.
- R10: The table and control bits are captured at `frm_start`. Host writes made in that cycle or during the address bytes affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table byte write strobe |
| tbl_page | input | 8 | Host register page number |
| tbl_offs | input | 3 | Byte offset within the page |
| tbl_wdata | input | 8 | Table byte write data |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control bits: bit 0 exact enable, bit 1 promiscuous, bit 2 all-group |
| frm_start | input | 1 | Start-of-frame pulse, precedes the address bytes |
| rx_valid | input | 1 | Destination byte valid |
| rx_byte | input | 8 | Destination byte, wire order |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_slot | output | 4 | Lowest matching slot, or 4'hF |

## Verification
The assertions take for granted that every frame is opened by a single `frm_start` pulse and that the MAC then supplies at least six address bytes before the next pulse. Only under that condition is each decision strobe tied to a sixth byte of the same frame. The bench always issues `frm_start` alone for one cycle, then six address bytes, optionally with idle gaps. As the only deliberate exception, it adds a junk byte in the start cycle or extra bytes after the sixth, in order to exercise the ignore rules. Host writes during a frame touch only slot 0 and the control bits, so the expected result can be worked out from the copy of the table taken at frame start.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int BYTE_W = 8;

  // control word: bit 2 all-group, bit 1 promiscuous, bit 0 exact enable
  typedef struct packed {
    logic allgrp;
    logic promisc;
    logic exact_en;
  } daf_ctl_t;
endpackage

// File: rtl/daf_table.sv
module daf_table #(
  parameter int         TBL_BYTES  = 60,
  parameter int         PAGES      = 8,
  parameter int         PAGE_BYTES = 8,
  parameter logic [7:0] PAGE_BASE  = 8'h50,
  localparam int        PG_W       = $clog2(PAGES),
  localparam int        OF_W       = $clog2(PAGE_BYTES),
  localparam int        AW         = PG_W + OF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [7:0]              page,
  input  logic [OF_W-1:0]         offs,
  input  logic [7:0]              wdata,
  output logic [TBL_BYTES*8-1:0]  tbl_flat
);
  logic [7:0]    rel;
  logic          in_win;
  logic [AW-1:0] addr;
  logic          hit;
  logic [7:0]    mem_q [TBL_BYTES];
  logic [7:0]    mem_d [TBL_BYTES];

  assign rel    = page - PAGE_BASE;
  assign in_win = (rel < 8'(PAGES));
  assign addr   = {rel[PG_W-1:0], offs};
  assign hit    = we && in_win;

  always_comb begin
    for (int b = 0; b < TBL_BYTES; b++) begin
      mem_d[b] = mem_q[b];
      if (hit && addr == AW'(b)) mem_d[b] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < TBL_BYTES; b++) mem_q[b] <= 8'hFF;
    end else if (we) begin
      for (int b = 0; b < TBL_BYTES; b++) mem_q[b] <= mem_d[b];
    end
  end

  for (genvar g = 0; g < TBL_BYTES; g++) begin : g_flat
    assign tbl_flat[g*8 +: 8] = mem_q[g];
  end

  // a write whose page misses the window must leave the table untouched
  assert_outside_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !in_win) |=> $stable(tbl_flat));
endmodule

// File: rtl/daf_slot_cmp.sv
module daf_slot_cmp #(
  parameter int  ADDR_BYTES    = 6,
  parameter bit  REVERSE_BYTES = 1'b0,
  localparam int CNT_W         = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [ADDR_BYTES*8-1:0] slot_bytes,
  input  logic                    byte_en,
  input  logic [CNT_W-1:0]        byte_idx,
  input  logic [7:0]              rx_byte,
  output logic                    hit
);
  logic [ADDR_BYTES*8-1:0] snap_q, snap_d;
  logic [ADDR_BYTES*8-1:0] ord;
  logic                    match_q, match_d;
  logic [7:0]              cur;

  // present the snapshot in wire order
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_ord
    if (REVERSE_BYTES) begin : g_rev
      assign ord[k*8 +: 8] = snap_q[(ADDR_BYTES-1-k)*8 +: 8];
    end else begin : g_fwd
      assign ord[k*8 +: 8] = snap_q[k*8 +: 8];
    end
  end

  always_comb begin
    cur = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (byte_idx == CNT_W'(k)) cur = ord[k*8 +: 8];
  end

  assign hit = match_q && (rx_byte == cur);

  always_comb begin
    snap_d  = snap_q;
    match_d = match_q;
    if (load) begin
      snap_d  = slot_bytes;
      match_d = 1'b1;
    end else if (byte_en) begin
      match_d = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '1;
      match_q <= 1'b0;
    end else begin
      snap_q  <= snap_d;
      match_q <= match_d;
    end
  end

  // a frame start re-arms the running match flag
  assert_load_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> match_q);
endmodule

// File: rtl/daf_prio.sv
module daf_prio #(
  parameter int  N     = 10,
  localparam int IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '1;
    for (int i = N - 1; i >= 0; i--)
      if (hits[i]) idx = IDX_W'(i);
  end
  assign any = |hits;
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int         SLOTS         = 10,
  parameter int         ADDR_BYTES    = 6,
  parameter int         PAGES         = 8,
  parameter int         PAGE_BYTES    = 8,
  parameter logic [7:0] PAGE_BASE     = 8'h50,
  parameter bit         REVERSE_BYTES = 1'b0,
  localparam int        TBL_BYTES     = SLOTS * ADDR_BYTES,
  localparam int        OFFS_W        = $clog2(PAGE_BYTES),
  localparam int        IDX_W         = $clog2(SLOTS + 1),
  localparam int        CNT_W         = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [7:0]        tbl_page,
  input  logic [OFFS_W-1:0] tbl_offs,
  input  logic [7:0]        tbl_wdata,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic              frm_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [IDX_W-1:0]  dec_slot
);
  import daf_pkg::*;

  localparam logic [IDX_W-1:0] NO_SLOT = '1;

  logic [TBL_BYTES*8-1:0] tbl_flat;
  logic [SLOTS-1:0]       hits, ex_hits;
  logic                   any_hit;
  logic [IDX_W-1:0]       low_idx;
  daf_ctl_t               ctl_q, ctl_d, snap_q, snap_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   grp_q, grp_d;
  logic                   byte_en, last, acc;
  logic                   dv_d, da_d;
  logic [IDX_W-1:0]       ds_d;

  daf_table #(.TBL_BYTES(TBL_BYTES), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES),
              .PAGE_BASE(PAGE_BASE)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .page(tbl_page), .offs(tbl_offs),
    .wdata(tbl_wdata), .tbl_flat(tbl_flat));

  assign byte_en = rx_valid && !frm_start && (cnt_q < CNT_W'(ADDR_BYTES));
  assign last    = byte_en && (cnt_q == CNT_W'(ADDR_BYTES - 1));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    daf_slot_cmp #(.ADDR_BYTES(ADDR_BYTES), .REVERSE_BYTES(REVERSE_BYTES)) u_cmp (
      .clk(clk), .rst_n(rst_n), .load(frm_start),
      .slot_bytes(tbl_flat[s*ADDR_BYTES*8 +: ADDR_BYTES*8]),
      .byte_en(byte_en), .byte_idx(cnt_q), .rx_byte(rx_byte), .hit(hits[s]));
  end

  assign ex_hits = hits & {SLOTS{snap_q.exact_en}};

  daf_prio #(.N(SLOTS)) u_prio (.hits(ex_hits), .any(any_hit), .idx(low_idx));

  assign acc = any_hit || snap_q.promisc || (snap_q.allgrp && grp_q);

  always_comb begin
    ctl_d  = ctl_we ? daf_ctl_t'(ctl_wdata) : ctl_q;
    snap_d = frm_start ? ctl_q : snap_q;
    cnt_d  = cnt_q;
    grp_d  = grp_q;
    if (frm_start) begin
      cnt_d = '0;
      grp_d = 1'b0;
    end else if (byte_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == '0) grp_d = rx_byte[0];
    end
    dv_d = last;
    da_d = last && acc;
    ds_d = (last && any_hit) ? low_idx : NO_SLOT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      snap_q     <= '0;
      cnt_q      <= CNT_W'(ADDR_BYTES);
      grp_q      <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_slot   <= NO_SLOT;
    end else begin
      ctl_q      <= ctl_d;
      snap_q     <= snap_d;
      cnt_q      <= cnt_d;
      grp_q      <= grp_d;
      dec_valid  <= dv_d;
      dec_accept <= da_d;
      dec_slot   <= ds_d;
    end
  end

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  assert_follows_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($past(rx_valid) && !$past(frm_start)));
  assert_slot_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_slot != NO_SLOT) |-> dec_accept);
  assert_reject_noslot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_accept |-> (dec_slot == NO_SLOT));
  assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && snap_q.promisc) |-> dec_accept);
  assert_lowest_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((ex_hits & ((SLOTS'(1) << low_idx) - SLOTS'(1))) == '0));
endmodule

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;
  localparam logic [7:0] BASE = 8'h50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [7:0] tbl_page = '0;
  logic [2:0] tbl_offs = '0;
  logic [7:0] tbl_wdata = '0;
  logic       ctl_we = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic       frm_start = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       dv_f, da_f, dv_r, da_r;
  logic [3:0] ds_f, ds_r;

  int nchk = 0;
  int nbad = 0;
  logic [7:0] tbl [60];
  logic [7:0] tbl_s [60];
  logic [2:0] ctl_m = '0;
  logic [2:0] ctl_s = '0;

  always #10 clk = ~clk;

  dest_addr_filter u_dest_addr_filter (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_page(tbl_page), .tbl_offs(tbl_offs),
    .tbl_wdata(tbl_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .frm_start(frm_start),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .dec_valid(dv_f), .dec_accept(da_f), .dec_slot(ds_f));

  dest_addr_filter #(.REVERSE_BYTES(1'b1)) u_rev (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_page(tbl_page), .tbl_offs(tbl_offs),
    .tbl_wdata(tbl_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .frm_start(frm_start),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .dec_valid(dv_r), .dec_accept(da_r), .dec_slot(ds_r));

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_wr(input logic [7:0] pg, input logic [2:0] of, input logic [7:0] d);
    logic [7:0] rel = pg - BASE;
    int a = int'(rel) * 8 + int'(of);
    if (rel < 8 && a < 60) tbl[a] = d;
  endtask

  task automatic host_wr(input logic [7:0] pg, input logic [2:0] of, input logic [7:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_page = pg; tbl_offs = of; tbl_wdata = d;
    model_wr(pg, of, d);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic set_ctl(input logic [2:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v; ctl_m = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // slot bytes given in storage order, first stored byte in [47:40]
  task automatic load_slot(input int s, input logic [47:0] m);
    for (int k = 0; k < 6; k++) begin
      int a = s * 6 + k;
      host_wr(BASE + 8'(a / 8), 3'(a % 8), m[47-8*k -: 8]);
    end
  endtask

  function automatic int exp_slot(input logic [47:0] d, input bit rev);
    for (int s = 0; s < 10; s++) begin
      bit eq = 1'b1;
      for (int k = 0; k < 6; k++)
        if (tbl_s[s*6+k] != d[47-8*(rev ? 5-k : k) -: 8]) eq = 1'b0;
      if (eq && ctl_s[0]) return s;
    end
    return 15;
  endfunction

  // d: destination in wire order, first byte in [47:40]
  task automatic send(input logic [47:0] d, input bit gaps, input bit junk,
                      input bit extra, input bit midwr, input string req);
    int es_f, es_r;
    bit ea_f, ea_r;
    @(negedge clk);
    tbl_s = tbl; ctl_s = ctl_m;
    frm_start = 1'b1; rx_valid = junk; rx_byte = junk ? 8'hA5 : 8'h00;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      frm_start = 1'b0; tbl_we = 1'b0; ctl_we = 1'b0;
      if (gaps && (k == 1 || k == 4)) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1; rx_byte = d[47-8*k -: 8];
      if (midwr && k == 2) begin
        tbl_we = 1'b1; tbl_page = BASE; tbl_offs = 3'd5; tbl_wdata = 8'h66;
        model_wr(BASE, 3'd5, 8'h66);
        ctl_we = 1'b1; ctl_wdata = 3'b000; ctl_m = 3'b000;
      end
    end
    @(negedge clk);
    rx_valid = extra; rx_byte = 8'h00; tbl_we = 1'b0; ctl_we = 1'b0;
    es_f = exp_slot(d, 1'b0);
    es_r = exp_slot(d, 1'b1);
    ea_f = (es_f != 15) || ctl_s[1] || (ctl_s[2] && d[40]);
    ea_r = (es_r != 15) || ctl_s[1] || (ctl_s[2] && d[40]);
    check(req, "valid", int'(dv_f), 1);
    check(req, "accept", int'(da_f), int'(ea_f));
    check(req, "slot", int'(ds_f), es_f);
    check("R3", "rev valid", int'(dv_r), 1);
    check("R3", "rev accept", int'(da_r), int'(ea_r));
    check("R3", "rev slot", int'(ds_r), es_r);
    @(negedge clk);
    check("R4", "pulse ends", int'(dv_f), 0);
    if (extra) begin
      @(negedge clk);
      check("R4", "extra bytes ignored", int'(dv_f), 0);
      rx_valid = 1'b0;
      @(negedge clk);
      check("R4", "extra bytes ignored", int'(dv_f), 0);
    end
  endtask

  localparam logic [47:0] STN  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MC1  = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC2  = 48'h01_00_5E_7F_00_02;
  localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] UNI  = 48'h02_99_88_77_66_55;
  localparam logic [47:0] UMC  = 48'h01_00_5E_11_22_33;

  task automatic t_reset;
    check("R1", "valid at reset", int'(dv_f), 0);
    check("R1", "accept at reset", int'(da_f), 0);
    check("R1", "slot at reset", int'(ds_f), 15);
    send(BC, 0, 0, 0, 0, "R1");          // control bits zero: reject
    set_ctl(3'b001);
    send(BC, 0, 0, 0, 0, "R6");          // all-ones table: slot 0
  endtask

  task automatic t_load;
    load_slot(0, STN);
    load_slot(1, MC1);
    load_slot(2, MC2);                   // slot 2 spans pages 1 and 2 (R2)
    load_slot(4, MC2);
    send(STN, 0, 0, 0, 0, "R5");
    send(MC1, 0, 0, 0, 0, "R5");
    send(MC2, 1, 0, 0, 0, "R5");         // duplicate in slot 4, lowest wins
    send(BC, 0, 0, 0, 0, "R6");          // first empty slot is 3
    send(UNI, 0, 0, 0, 0, "R9");
    send(48'h02_11_22_33_44_56, 0, 0, 0, 0, "R5");
  endtask

  task automatic t_window;
    host_wr(BASE + 8'd8, 3'd0, 8'h00);
    host_wr(BASE - 8'd1, 3'd7, 8'h00);
    host_wr(BASE + 8'd7, 3'd4, 8'h00);
    send(STN, 0, 0, 0, 0, "R2");
    load_slot(9, 48'h02_AA_BB_CC_DD_EE); // last slot, pages 6 and 7
    send(48'h02_AA_BB_CC_DD_EE, 0, 0, 0, 0, "R2");
    send(STN, 0, 1, 1, 0, "R4");         // junk start byte, extra tail bytes
  endtask

  task automatic t_promisc;
    set_ctl(3'b011);
    send(UNI, 0, 0, 0, 0, "R7");
    send(STN, 0, 0, 0, 0, "R7");
    set_ctl(3'b010);
    send(STN, 0, 0, 0, 0, "R9");         // exact off: slot F
  endtask

  task automatic t_allgrp;
    set_ctl(3'b101);
    send(UMC, 0, 0, 0, 0, "R8");
    send(UNI, 0, 0, 0, 0, "R8");
    send(MC1, 0, 0, 0, 0, "R8");
    set_ctl(3'b100);
    send(MC1, 1, 0, 0, 0, "R8");
  endtask

  task automatic t_snapshot;
    set_ctl(3'b001);
    send(STN, 0, 0, 0, 1, "R10");        // mid-frame writes unseen
    send(STN, 0, 0, 0, 0, "R10");        // control now zero: reject
    set_ctl(3'b001);
    send(STN, 0, 0, 0, 0, "R10");        // byte 5 changed: reject
    send(48'h02_11_22_33_44_66, 0, 0, 0, 0, "R10");
  endtask

  task automatic t_reverse;
    load_slot(6, 48'h0A_0B_0C_0D_0E_0F);
    send(48'h0A_0B_0C_0D_0E_0F, 0, 0, 0, 0, "R3");
    send(48'h0F_0E_0D_0C_0B_0A, 0, 0, 0, 0, "R3");
  endtask

  initial begin
    for (int i = 0; i < 60; i++) tbl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_window();
    t_promisc();
    t_allgrp();
    t_snapshot();
    t_reverse();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule